// File: doc/BRIEF.md
# Staged SerDes Reset Sequencer

This block owns the power-down, PLL-reset and lane-reset controls of a four-lane serial transceiver and brings them out of reset in a fixed, timed order. A one-cycle start pulse drives every control high at once. After a programmable dwell the controls are released one group at a time, with one dwell after each release. The lane pair 0/1 is fully released (power-down, then its shared PLL reset, then its lane resets) before the pair 2/3 follows the same three steps.

The dwell length is set in clock cycles from two parameters, the clock frequency in MHz and the dwell in microseconds, so a 15 us dwell can be met at any clock. A busy flag covers the whole sequence and a one-cycle done pulse marks its end. A static per-port configuration word is carried through a register next to the controls and the sequence never touches it. All outputs are registered and reset is synchronous and active-high.

Top module: `serdes_rst_seq`

## Requirements
- R1: While rst is high, on the following clock edge every control bit (lane_pd[3:0], pll_rst[1:0], lane_rst[3:0]) is 1 and busy and done are 0.
- R2: A start pulse sampled while busy is 0 sets every control bit to 1 and busy to 1 at that same edge (call it edge S).
- R3: The release order is fixed: lane_pd[0] and lane_pd[1] together, then pll_rst[0] (shared PLL of lanes 0/1), then lane_rst[0] and lane_rst[1], then lane_pd[2] and lane_pd[3], then pll_rst[1] (shared PLL of lanes 2/3), then lane_rst[2] and lane_rst[3]; bit i of lane_pd and lane_rst belongs to lane i. No control returns to 1 while busy stays high.
- R4: With D = CLK_FREQ_MHZ * DWELL_US cycles, release step k (k = 1..6) takes effect at edge S + k*D.
- R5: busy stays 1 up to edge S + 7*D, falls there, and done is 1 for exactly the one cycle after that edge.
- R6: A start pulse sampled while busy is 1 is ignored: the release times and busy/done timing stay those of the running sequence.
- R7: cfg_out equals the cfg_in value sampled at the previous clock edge, independent of the sequence.
- R8: After done, all control bits stay 0 until the next accepted start.
- R9: Raising rst in the middle of a sequence returns every control to 1 with busy 0 at the next edge, and a later start runs a full sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| cfg_in | input | CFG_W | Static per-port configuration word |
| lane_pd | output | 4 | Lane power-down controls, bit i for lane i |
| pll_rst | output | 2 | PLL resets, bit 0 lanes 0/1, bit 1 lanes 2/3 |
| lane_rst | output | 4 | Lane resets, bit i for lane i |
| cfg_out | output | CFG_W | Registered copy of cfg_in |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse when the last dwell ends |

## Verification
Every result is due relative to the edge S that samples the start pulse: all controls and busy change at S itself, release step k at S + k*D, busy falls and done rises at S + 7*D, and cfg_out follows cfg_in one edge later. The bench drives inputs on the falling edge and, from S on, samples every output on each falling edge, computing the expected control vector from the cycle count c since S, so a release one cycle early or late is caught. A second start pulse is injected at chosen cycles, including the last busy cycle, and the same expected trace must result.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int LANES     = 4;
  localparam int PAIRS     = LANES / 2;
  localparam int STEPS_PER = 3;
  localparam int N_STEPS   = PAIRS * STEPS_PER;
  localparam int SW        = $clog2(N_STEPS + 1);

  typedef logic [SW-1:0] rel_t;
endpackage

// File: rtl/srs_dwell_timer.sv
module srs_dwell_timer #(
  parameter int DWELL_CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (expire) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/srs_step_seq.sv
module srs_step_seq
  import srs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic expire,
  output rel_t rel_d,
  output logic busy_q,
  output logic done_q
);
  localparam rel_t LAST = rel_t'(N_STEPS);

  rel_t rel_q;
  logic busy_d, done_d, accept;

  always_comb begin
    rel_d  = rel_q;
    busy_d = busy_q;
    done_d = 1'b0;
    accept = start && !busy_q;
    if (accept) begin
      rel_d  = '0;
      busy_d = 1'b1;
    end else if (expire) begin
      if (rel_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        rel_d = rel_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rel_q  <= rel_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> (busy_q && rel_q == '0));

  // R6
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy_q && !expire) |=> $stable(rel_q));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3
  rel_range_chk: assert property (@(posedge clk) disable iff (rst)
    rel_q <= LAST);
endmodule

// File: rtl/srs_pair_decode.sv
module srs_pair_decode
  import srs_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input  rel_t       rel,
  output logic [1:0] pd,
  output logic       pll,
  output logic [1:0] lrst
);
  localparam rel_t TH_PD  = rel_t'(PAIR_IDX * STEPS_PER + 1);
  localparam rel_t TH_PLL = rel_t'(PAIR_IDX * STEPS_PER + 2);
  localparam rel_t TH_RST = rel_t'(PAIR_IDX * STEPS_PER + 3);

  always_comb begin
    pd   = {2{rel < TH_PD}};
    pll  = (rel < TH_PLL);
    lrst = {2{rel < TH_RST}};
  end
endmodule

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq
  import srs_pkg::*;
#(
  parameter int CLK_FREQ_MHZ = 100,
  parameter int DWELL_US     = 15,
  parameter int CFG_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [3:0]       lane_pd,
  output logic [1:0]       pll_rst,
  output logic [3:0]       lane_rst,
  output logic [CFG_W-1:0] cfg_out,
  output logic             busy,
  output logic             done
);
  localparam int DWELL_CYC = (CLK_FREQ_MHZ * DWELL_US > 0) ? CLK_FREQ_MHZ * DWELL_US : 1;

  logic expire;
  rel_t rel_d;
  logic [LANES-1:0] pd_d, rst_d;
  logic [PAIRS-1:0] pll_d;

  srs_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .expire(expire)
  );

  srs_step_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .expire(expire),
    .rel_d(rel_d), .busy_q(busy), .done_q(done)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    srs_pair_decode #(.PAIR_IDX(p)) u_dec (
      .rel (rel_d),
      .pd  (pd_d[2*p +: 2]),
      .pll (pll_d[p]),
      .lrst(rst_d[2*p +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_pd  <= '1;
      pll_rst  <= '1;
      lane_rst <= '1;
    end else begin
      lane_pd  <= pd_d;
      pll_rst  <= pll_d;
      lane_rst <= rst_d;
    end
  end

  always_ff @(posedge clk) cfg_out <= cfg_in;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (&lane_pd && &pll_rst && &lane_rst && !busy && !done));

  // R3
  no_reassert_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (((lane_pd & ~$past(lane_pd)) == '0) &&
       ((pll_rst & ~$past(pll_rst)) == '0) &&
       ((lane_rst & ~$past(lane_rst)) == '0)));

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable({lane_pd, pll_rst, lane_rst}));

  // R7
  cfg_pass_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_out == $past(cfg_in));
endmodule

// File: tb/serdes_rst_seq_bench.sv
module serdes_rst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 3;
  localparam int US  = 5;
  localparam int D   = MHZ * US;
  localparam int CW  = 8;
  localparam int NV  = 4;
  // each entry: {cfg word, cycle index c at which a second start is driven (255 = none)}
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 8'd255},
    {8'h3C, 8'(D - 1)},
    {8'h00, 8'(3 * D)},
    {8'hFF, 8'(7 * D - 1)}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] cfg_in = '0;
  logic [3:0] lane_pd, lane_rst;
  logic [1:0] pll_rst;
  logic [CW-1:0] cfg_out;
  logic busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serdes_rst_seq #(.CLK_FREQ_MHZ(MHZ), .DWELL_US(US), .CFG_W(CW)) u_serdes_rst_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in),
    .lane_pd(lane_pd), .pll_rst(pll_rst), .lane_rst(lane_rst),
    .cfg_out(cfg_out), .busy(busy), .done(done)
  );

  // packed {lane_pd, pll_rst, lane_rst, busy, done}
  function automatic logic [11:0] expect_at(int c);
    int r;
    logic [3:0] pd, lr;
    logic [1:0] pl;
    r = (c >= 6 * D) ? 6 : c / D;
    pd = {{2{r < 4}}, {2{r < 1}}};
    pl = {r < 5, r < 2};
    lr = {{2{r < 6}}, {2{r < 3}}};
    return {pd, pl, lr, (c < 7 * D), (c == 7 * D)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_seq(logic [CW-1:0] cfg, int dup);
    @(negedge clk);
    cfg_in = cfg;
    start = 1'b1;
    @(negedge clk);
    for (int c = 0; c <= 7 * D + 1; c++) begin
      logic [11:0] act;
      act = {lane_pd, pll_rst, lane_rst, busy, done};
      if (c == 0)               check("R2 all asserted at start", 32'(act), 32'(expect_at(c)));
      else if (c >= 7 * D)      check("R5 busy/done end", 32'(act), 32'(expect_at(c)));
      else if (dup != 255)      check("R6 restart ignored", 32'(act), 32'(expect_at(c)));
      else                      check("R3 R4 release order/spacing", 32'(act), 32'(expect_at(c)));
      check("R7 cfg unchanged", 32'(cfg_out), 32'(cfg));
      start = (c == dup);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'({lane_pd, pll_rst, lane_rst, busy, done}), 32'(12'hFFC));
    rst = 1'b0;
    @(negedge clk);
    check("R1 held after reset", 32'({lane_pd, pll_rst, lane_rst, busy, done}), 32'(12'hFFC));

    for (int v = 0; v < NV; v++) begin
      run_seq(VEC[v][15:8], int'(VEC[v][7:0]));
      repeat (4) @(negedge clk);
      check("R8 released while idle", 32'({lane_pd, pll_rst, lane_rst, busy, done}), 32'(12'h000));
    end

    // R7: one-edge latency
    cfg_in = 8'h5A;
    #1;
    check("R7 before edge", 32'(cfg_out), 32'(8'hFF));
    @(negedge clk);
    check("R7 after edge", 32'(cfg_out), 32'(8'h5A));

    // R9: reset mid-sequence
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * D + 3) @(negedge clk);
    check("R9 mid state", 32'({lane_pd, pll_rst, lane_rst, busy, done}),
          32'(expect_at(2 * D + 3)));
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset mid-seq", 32'({lane_pd, pll_rst, lane_rst, busy, done}), 32'(12'hFFC));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 idle after reset", 32'({lane_pd, pll_rst, lane_rst, busy, done}), 32'(12'hFFC));
    run_seq(8'h77, 255);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule